// File: doc/BRIEF.md
# Timed Write-Protection Gate

This block guards a bank of clock-configuration registers against stray writes. It watches every bus write. Writes to one control address carry a 2-bit key code in data bits [1:0]. When software writes the correct run of key codes to that address, the block opens a write window. The window is timed in ticks of a 1 Hz strobe that the block receives as an input. When the window runs out, or when software writes to the control address again, the block locks the bank.

Out of reset the bank starts unlocked and gets a longer start-up window, so boot code can configure the clock without the key run. For each write to any other address, the block produces a qualifier `wr_allow` that the register bank uses as its write enable. It also drives a `locked` status bit.

Top module: `wprot_gate`

## Requirements
- R1: After a synchronous reset, `locked` is 0, so the bank is open for the start-up window.
- R2: With no control write, the start-up window lasts INIT_SECS (default 15) ticks. `locked` stays 0 through tick INIT_SECS-1 and is 1 in the cycle after tick INIT_SECS.
- R3: While `locked` is 1, `wr_allow` is 0 for every write. Lock stays in force until a complete key run is written.
- R4: While `locked` is 0, `wr_allow` is 1 exactly when `wr_en` is 1 and `wr_addr` is not CTRL_ADDR.
- R5: Four control writes whose bits [1:0] are 2'b00, 2'b01, 2'b11, 2'b10, in that order, unlock the bank. `locked` is 0 in the cycle after the fourth write.
- R6: A control write whose code does not match the expected step restarts detection. If that code is 2'b00, it counts as the first step. Any other wrong code sets the detector back to the start.
- R7: A write to any other address between key steps sets the detector back to the start.
- R8: A window opened by a key run lasts OPEN_SECS (default 2) ticks. `locked` is still 0 after the first tick and is 1 after the second.
- R9: While unlocked, a control write that does not complete the key run relocks the bank in the next cycle.
- R10: A complete key run written while the bank is unlocked restarts the window from a full OPEN_SECS.
- R11: Cycles with no write between key steps do not disturb detection.
- R12: If the final key write and a tick fall in the same cycle, the new window opens with its full length and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; bits [1:0] carry the key code on the control address |
| wr_allow | output | 1 | Write enable for the protected register at wr_addr |
| locked | output | 1 | 1 while protected writes are blocked |

## Verification
The bench writes every one of the 256 four-code control runs, starting from a cleared detector. A detector that accepted a wrong order or a partial run would unlock on the wrong run. Near-miss runs check the restart rules. After a wrong 2'b00, a detector that went fully back to the start would miss the unlock. A detector that ignored writes to other addresses would unlock across an interruption. The window edges are checked tick by tick. An off-by-one counter would lock one tick early or one tick late. Two further cases are checked: a key run written inside an open window, and a final key write that lands on a tick. A design that kept the old count, or counted that tick, would lock one tick too soon.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [1:0] {
    STEP0 = 2'd0,
    STEP1 = 2'd1,
    STEP2 = 2'd2,
    STEP3 = 2'd3
  } seq_step_e;

  localparam logic [1:0] KEY_A = 2'b00;
  localparam logic [1:0] KEY_B = 2'b01;
  localparam logic [1:0] KEY_C = 2'b11;
  localparam logic [1:0] KEY_D = 2'b10;

  function automatic logic [1:0] key_for(seq_step_e s);
    case (s)
      STEP0:   key_for = KEY_A;
      STEP1:   key_for = KEY_B;
      STEP2:   key_for = KEY_C;
      default: key_for = KEY_D;
    endcase
  endfunction

endpackage

// File: rtl/key_seq_detect.sv
module key_seq_detect
  import wprot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic       other_wr,
  input  logic [1:0] code,
  output logic       done
);

  seq_step_e  step_q;
  logic [1:0] expect_code;
  logic       hit;

  always_comb begin
    expect_code = key_for(step_q);
    hit         = ctrl_wr && (code == expect_code);
    done        = hit && (step_q == STEP3);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= STEP0;
    end else if (other_wr) begin
      step_q <= STEP0;
    end else if (ctrl_wr) begin
      if (hit) begin
        step_q <= (step_q == STEP3) ? STEP0 : seq_step_e'(step_q + 2'd1);
      end else begin
        step_q <= (code == KEY_A) ? STEP1 : STEP0;
      end
    end
  end

  p_clear_on_other_r7: assert property (@(posedge clk) disable iff (rst)
    other_wr |=> (step_q == STEP0));

  p_idle_holds_r11: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && !other_wr) |=> $stable(step_q));

  p_done_rearms_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> (step_q == STEP0));

  p_wrong_a_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !other_wr && step_q != STEP0 && code == KEY_A) |=> (step_q == STEP1));

endmodule

// File: rtl/window_timer.sv
module window_timer #(
  parameter int INIT_SECS = 15,
  parameter int OPEN_SECS = 2,
  localparam int MAX_SECS = (INIT_SECS > OPEN_SECS) ? INIT_SECS : OPEN_SECS,
  localparam int CNT_W    = $clog2(MAX_SECS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic open_req,
  input  logic close_req,
  output logic locked_o
);

  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_SECS - 1);
  localparam logic [CNT_W-1:0] OPEN_LAST = CNT_W'(OPEN_SECS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;
  logic             locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      cnt_q    <= '0;
      last_q   <= INIT_LAST;
    end else if (open_req) begin
      locked_q <= 1'b0;
      cnt_q    <= '0;
      last_q   <= OPEN_LAST;
    end else if (close_req) begin
      locked_q <= 1'b1;
      cnt_q    <= '0;
    end else if (tick && !locked_q) begin
      if (cnt_q == last_q) begin
        locked_q <= 1'b1;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign locked_o = locked_q;

  p_open_r5: assert property (@(posedge clk) disable iff (rst)
    open_req |=> !locked_q);

  p_close_r9: assert property (@(posedge clk) disable iff (rst)
    (close_req && !open_req) |=> locked_q);

  p_hold_lock_r3: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !open_req) |=> locked_q);

  p_no_early_lock_r8: assert property (@(posedge clk) disable iff (rst)
    (!locked_q && !tick && !close_req) |=> !locked_q);

  p_tick_bounded_r12: assert property (@(posedge clk) disable iff (rst)
    (!locked_q && tick && !close_req && !open_req) |=> (cnt_q <= last_q));

endmodule

// File: rtl/wprot_gate.sv
module wprot_gate #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 0,
  parameter int INIT_SECS = 15,
  parameter int OPEN_SECS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_allow,
  output logic              locked
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic ctrl_wr;
  logic other_wr;
  logic seq_done;
  logic lock_q;

  assign ctrl_wr  = wr_en && (wr_addr == CTRL_A);
  assign other_wr = wr_en && (wr_addr != CTRL_A);

  key_seq_detect u_seq (
    .clk      (clk),
    .rst      (rst),
    .ctrl_wr  (ctrl_wr),
    .other_wr (other_wr),
    .code     (wr_data[1:0]),
    .done     (seq_done)
  );

  window_timer #(
    .INIT_SECS (INIT_SECS),
    .OPEN_SECS (OPEN_SECS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_1hz),
    .open_req  (seq_done),
    .close_req (ctrl_wr),
    .locked_o  (lock_q)
  );

  assign wr_allow = other_wr && !lock_q;
  assign locked   = lock_q;

  p_ctrl_never_allowed_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CTRL_A) |-> !wr_allow);

  p_reset_open_r1: assert property (@(posedge clk)
    $past(rst) |-> !locked);

endmodule

// File: tb/wprot_gate_test.sv
`timescale 1ns/1ps
module wprot_gate_test;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick_1hz = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              wr_allow;
  logic              locked;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  wprot_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(0),
               .INIT_SECS(15), .OPEN_SECS(2)) uut (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_allow(wr_allow), .locked(locked));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = {6'h15, d};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic unlock();
    wr(0, 2'b00); wr(0, 2'b01); wr(0, 2'b11); wr(0, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [1:0] codes [4];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset open", locked, 1'b0);

    // R4: allow qualifier while open
    wr_en = 1'b1; wr_addr = 4'd5; #0.1;
    check("R4 allow other addr", wr_allow, 1'b1);
    wr_addr = 4'd0; #0.1;
    check("R4 no allow ctrl addr", wr_allow, 1'b0);
    wr_en = 1'b0; wr_addr = 4'd5; #0.1;
    check("R4 no allow without strobe", wr_allow, 1'b0);

    // R2: start-up window
    for (int i = 1; i <= 14; i++) begin
      tick();
      check("R2 open before limit", locked, 1'b0);
    end
    tick();
    check("R2 locked at limit", locked, 1'b1);

    // R3
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd7; #0.1;
    check("R3 blocked write", wr_allow, 1'b0);
    wr_en = 1'b0;

    // R5: sweep all four-code runs
    for (int s = 0; s < 256; s++) begin
      for (int k = 0; k < 4; k++) codes[k] = 2'((s >> (2 * (3 - k))) & 3);
      wr(4'd1, 2'b00);
      for (int k = 0; k < 4; k++) wr(0, codes[k]);
      check($sformatf("R5 run %0d", s), locked,
            (s == 8'b00_01_11_10) ? 1'b0 : 1'b1);
      if (!locked) begin
        wr(0, 2'b11);
        check("R9 relock after sweep", locked, 1'b1);
      end
    end

    // R8
    wr(4'd1, 2'b00);
    unlock();
    check("R8 open after run", locked, 1'b0);
    tick();
    check("R8 open after one tick", locked, 1'b0);
    tick();
    check("R8 locked after two ticks", locked, 1'b1);

    // R9
    unlock();
    wr(0, 2'b01);
    check("R9 ctrl write relocks", locked, 1'b1);

    // R10
    wr(4'd1, 2'b00);
    unlock();
    tick();
    unlock();
    check("R10 open after rerun", locked, 1'b0);
    tick();
    check("R10 window restarted", locked, 1'b0);
    tick();
    check("R10 locks after full window", locked, 1'b1);

    // R6
    wr(4'd1, 2'b00);
    wr(0, 2'b00); wr(0, 2'b01); wr(0, 2'b00); wr(0, 2'b01); wr(0, 2'b11); wr(0, 2'b10);
    check("R6 wrong 00 counts as step one", locked, 1'b0);
    wr(0, 2'b11);
    wr(4'd1, 2'b00);
    wr(0, 2'b00); wr(0, 2'b01); wr(0, 2'b01); wr(0, 2'b11); wr(0, 2'b10);
    check("R6 wrong code restarts", locked, 1'b1);
    wr(0, 2'b00); wr(0, 2'b01); wr(0, 2'b11); wr(0, 2'b00);
    wr(0, 2'b01); wr(0, 2'b11); wr(0, 2'b10);
    check("R6 wrong at last step 00", locked, 1'b0);
    wr(0, 2'b11);

    // R7
    wr(4'd1, 2'b00);
    wr(0, 2'b00); wr(0, 2'b01); wr(4'd9, 2'b00); wr(0, 2'b11); wr(0, 2'b10);
    check("R7 other write clears", locked, 1'b1);

    // R11
    wr(4'd1, 2'b00);
    wr(0, 2'b00);
    repeat (5) @(negedge clk);
    wr(0, 2'b01);
    repeat (3) @(negedge clk);
    wr(0, 2'b11); wr(0, 2'b10);
    check("R11 idle gaps tolerated", locked, 1'b0);

    // R12
    tick();
    wr(0, 2'b00); wr(0, 2'b01); wr(0, 2'b11);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 0; wr_data = 8'h02; tick_1hz = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_1hz = 1'b0;
    check("R12 open on final write with tick", locked, 1'b0);
    tick();
    check("R12 tick not counted", locked, 1'b0);
    tick();
    check("R12 locks after full window", locked, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule